// File: doc/BRIEF.md
# Rotated Byte Immediate Encoder

This block decides whether a 32-bit constant can be written as an 8-bit value rotated right by an even number of bit positions. Such a constant fits a 12-bit immediate field. The field holds an 8-bit value `n` (0 to 255) and a 4-bit rotation code `r`, and the constant it stands for is `n` rotated right by `2*r` bits. When the constant can be encoded, the block returns `n` and `r`. When it cannot, the block flags it as unrepresentable. The block also expands the returned pair back to 32 bits, so the result can be cross-checked against the input.

Constants arrive on a valid/ready stream, and results leave on a second valid/ready stream. All sixteen rotation candidates are tested in parallel on the incoming word. The winning candidate is stored in a one-entry output register, so a result appears the cycle after its input is accepted.

Back-pressure works as follows. An input is taken on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its result is being consumed in the same cycle. With `out_ready` held high, the block accepts one constant per cycle. While `out_valid` is high and `out_ready` is low, the held result does not change and no new input is taken.

Top module: `rotimm_codec`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An input accepted on a rising edge (`in_valid` and `in_ready` both high) produces `out_valid` = 1 from that edge until its result is consumed. Accepting on every edge with `out_ready` high gives one result per cycle, in input order.
- R3: `in_ready` is 0 exactly when `out_valid` is 1 and `out_ready` is 0. No input is taken in such a cycle.
- R4: While `out_valid` is 1 and `out_ready` is 0, the outputs `out_valid`, `out_ok`, `out_byte`, `out_rot` and `out_decoded` keep their values into the next cycle.
- R5: `out_ok` is 1 exactly when some `n` in 0..255 and some `r` in 0..15 exist such that the input equals `n` rotated right by `2*r` bits within 32 bits.
- R6: When several encodings exist, the one with the smallest `r` is returned. Inputs 0..255 return `r` = 0 and `n` equal to the input, so 0 returns `n` = 0, `r` = 0.
- R7: An unrepresentable input returns `out_ok` = 0, `out_byte` = 0, `out_rot` = 0 and `out_decoded` = 0.
- R8: `out_decoded` equals `out_byte` rotated right by `2*out_rot` bits, zero-extended to 32 bits. When `out_ok` is 1, it equals the accepted input.
- R9: Encoding examples:
  - 256 gives `n` = 1, `r` = 12.
  - 484 gives `n` = 121, `r` = 15.
  - 0x06000000 gives `n` = 6, `r` = 4.
  - 0xF000000F gives `n` = 0xFF, `r` = 2.
  - 0x80000001 gives `n` = 6, `r` = 1.
  - 511, 370, 0x06010000 and 0xFFFFFFFF are unrepresentable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A constant is offered on `in_value` |
| in_ready | output | 1 | The block will take the offered constant on this edge |
| in_value | input | 32 | Constant to encode |
| out_valid | output | 1 | A result is held on the output ports |
| out_ready | input | 1 | The consumer takes the held result on this edge |
| out_ok | output | 1 | The constant is representable |
| out_byte | output | 8 | 8-bit value `n` of the encoding |
| out_rot | output | 4 | Rotation code `r`; the rotation is `2*r` bits right |
| out_decoded | output | 32 | `out_byte` rotated right by `2*out_rot` bits |

## Verification
All results are due one cycle after the accepting edge, and `in_ready` follows the current output state with no delay. The bench drives its inputs and samples the ports at the falling edge. It keeps its own model of the output register and advances that model at each rising edge using the handshake it has just driven. The outputs are therefore compared, on every cycle, with what the model says they must hold at that moment.

The directed encodings are each checked on the cycle right after their single accepting edge. The random stream mixes stalls and accepts, so it covers results held under back-pressure as well as one-per-cycle throughput.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ROT_W    = 4;
  localparam int unsigned NUM_ROT  = 1 << ROT_W;
  localparam int unsigned ROT_STEP = WORD_W / NUM_ROT;
  localparam int unsigned SH_W     = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ROT_W-1:0]  rot_t;

  typedef struct packed {
    logic  ok;
    byte_t n;
    rot_t  r;
  } enc_t;
endpackage

// File: rtl/rotimm_lane.sv
// One rotation candidate: undo a right rotation of AMOUNT bits and test
// whether what remains fits in the low byte.
module rotimm_lane
  import rotimm_pkg::*;
#(
  parameter int unsigned AMOUNT = 0
) (
  input  word_t value,
  output logic  hit,
  output byte_t n
);
  localparam int unsigned BACK = (WORD_W - AMOUNT) % WORD_W;

  word_t lifted;

  assign lifted = (value << AMOUNT) | (value >> BACK);
  assign hit    = (lifted[WORD_W-1:BYTE_W] == '0);
  assign n      = lifted[BYTE_W-1:0];
endmodule

// File: rtl/rotimm_pick.sv
// Chooses the lowest rotation code among the fitting candidates.
module rotimm_pick
  import rotimm_pkg::*;
(
  input  logic [NUM_ROT-1:0] hit,
  input  byte_t              lane_n [NUM_ROT],
  output enc_t               enc
);
  always_comb begin
    enc = '0;
    for (int i = NUM_ROT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        enc.ok = 1'b1;
        enc.n  = lane_n[i];
        enc.r  = rot_t'(i);
      end
    end
  end

  always_comb begin
    // R5
    pick_hit_chk: assert (!enc.ok || hit[enc.r]);
    for (int i = 0; i < NUM_ROT; i++) begin
      // R6
      if (enc.ok && (i < int'(enc.r))) lowest_rot_chk: assert (!hit[i]);
    end
  end
endmodule

// File: rtl/rotimm_expand.sv
// Rebuilds the 32-bit constant from a byte and a rotation code.
module rotimm_expand
  import rotimm_pkg::*;
(
  input  byte_t n,
  input  rot_t  r,
  output word_t value
);
  word_t           wide;
  logic [SH_W-1:0] amt;

  assign wide  = word_t'(n);
  assign amt   = SH_W'(ROT_STEP * r);
  assign value = (wide >> amt) | (wide << (SH_W'(WORD_W) - amt));
endmodule

// File: rtl/rotimm_codec.sv
module rotimm_codec
  import rotimm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_value,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_ok,
  output logic [7:0]  out_byte,
  output logic [3:0]  out_rot,
  output logic [31:0] out_decoded
);
  logic               accept;
  logic [NUM_ROT-1:0] lane_hit;
  byte_t              lane_n [NUM_ROT];
  enc_t               found;
  enc_t               held;
  logic               held_valid;

  assign in_ready = !held_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < NUM_ROT; g++) begin : g_lane
    rotimm_lane #(.AMOUNT(g * ROT_STEP)) u_lane (
      .value (in_value),
      .hit   (lane_hit[g]),
      .n     (lane_n[g])
    );
  end

  rotimm_pick u_pick (
    .hit    (lane_hit),
    .lane_n (lane_n),
    .enc    (found)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held       <= '0;
    end else if (accept) begin
      held_valid <= 1'b1;
      held       <= found;
    end else if (out_ready) begin
      held_valid <= 1'b0;
    end
  end

  assign out_valid = held_valid;
  assign out_ok    = held.ok;
  assign out_byte  = held.n;
  assign out_rot   = held.r;

  rotimm_expand u_expand (
    .n     (held.n),
    .r     (held.r),
    .value (out_decoded)
  );

  // R2
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R3
  no_accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ok) &&
      $stable(out_byte) && $stable(out_rot) && $stable(out_decoded)));

  // R7
  reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> (out_byte == '0 && out_rot == '0 && out_decoded == '0));

  // R8
  roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!out_ok || out_decoded == $past(in_value)));
endmodule

// File: tb/rotimm_codec_tb.sv
module rotimm_codec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STREAM_CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_value = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_ok;
  logic [7:0]  out_byte;
  logic [3:0]  out_rot;
  logic [31:0] out_decoded;

  int n_check = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rotimm_codec u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_value    (in_value),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_ok      (out_ok),
    .out_byte    (out_byte),
    .out_rot     (out_rot),
    .out_decoded (out_decoded)
  );

  function automatic logic [31:0] ror(logic [31:0] x, int s);
    int k = s % 32;
    if (k == 0) return x;
    return (x >> k) | (x << (32 - k));
  endfunction

  // Reference: try rotation codes from low to high.
  function automatic void ref_enc(input logic [31:0] v, output bit ok,
                                  output logic [7:0] n, output logic [3:0] r);
    ok = 1'b0; n = '0; r = '0;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] back;
      back = ror(v, 32 - 2 * k);
      if (!ok && back < 32'd256) begin
        ok = 1'b1; n = back[7:0]; r = 4'(k);
      end
    end
  endfunction

  task automatic chk(bit cond, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_check++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_check - n_fail, n_check);
      $finish;
    end
  endtask

  // Single directed constant with hand-computed expectations.
  task automatic probe(logic [31:0] v, bit eok, logic [7:0] en, logic [3:0] er, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_value = v; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2", "out_valid", 32'(out_valid), 32'd1);
    chk(out_ok == eok, tag, "out_ok", 32'(out_ok), 32'(eok));
    chk(out_byte == en, tag, "out_byte", 32'(out_byte), 32'(en));
    chk(out_rot == er, tag, "out_rot", 32'(out_rot), 32'(er));
    chk(out_decoded == (eok ? v : 32'd0), "R8", "out_decoded", out_decoded, eok ? v : 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_check++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit          exp_valid = 1'b0;
    bit          exp_ok = 1'b0;
    logic [7:0]  exp_n = '0;
    logic [3:0]  exp_r = '0;
    logic [31:0] exp_v = '0;
    bit          held = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);

    probe(32'd0,        1'b1, 8'd0,   4'd0,  "R6");
    probe(32'd255,      1'b1, 8'd255, 4'd0,  "R6");
    probe(32'd37,       1'b1, 8'd37,  4'd0,  "R6");
    probe(32'd256,      1'b1, 8'd1,   4'd12, "R9");
    probe(32'd484,      1'b1, 8'd121, 4'd15, "R9");
    probe(32'h06000000, 1'b1, 8'd6,   4'd4,  "R9");
    probe(32'hF000000F, 1'b1, 8'hFF,  4'd2,  "R9");
    probe(32'h80000001, 1'b1, 8'd6,   4'd1,  "R9");
    probe(32'h000003FC, 1'b1, 8'hFF,  4'd15, "R5");
    probe(32'hFF000000, 1'b1, 8'hFF,  4'd4,  "R5");
    probe(32'd511,      1'b0, 8'd0,   4'd0,  "R7");
    probe(32'd370,      1'b0, 8'd0,   4'd0,  "R7");
    probe(32'h06010000, 1'b0, 8'd0,   4'd0,  "R7");
    probe(32'hFFFFFFFF, 1'b0, 8'd0,   4'd0,  "R7");

    // Drain: out_ready stays high, so the last result leaves at the next edge.
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "out_valid after drain", 32'(out_valid), 32'd0);

    for (int cyc = 0; cyc < STREAM_CYCLES; cyc++) begin
      bit          fire;
      bit          pop;
      logic [7:0]  b;
      logic [31:0] v;
      string       tag;

      // Compare the ports with the model.
      chk(out_valid == exp_valid, "R2", "out_valid", 32'(out_valid), 32'(exp_valid));
      chk(in_ready == (!exp_valid || out_ready), "R3", "in_ready",
          32'(in_ready), 32'(!exp_valid || out_ready));
      if (exp_valid) begin
        tag = held ? "R4" : "R5";
        chk(out_ok == exp_ok, tag, "out_ok", 32'(out_ok), 32'(exp_ok));
        chk(out_byte == exp_n, held ? "R4" : "R6", "out_byte", 32'(out_byte), 32'(exp_n));
        chk(out_rot == exp_r, held ? "R4" : "R6", "out_rot", 32'(out_rot), 32'(exp_r));
        chk(out_decoded == (exp_ok ? exp_v : 32'd0), "R8", "out_decoded",
            out_decoded, exp_ok ? exp_v : 32'd0);
      end

      // New stimulus.
      b = 8'($urandom);
      case ($urandom_range(0, 3))
        0: v = $urandom;
        1: v = ror(32'(b), 2 * int'($urandom_range(0, 15)));
        2: v = 32'(b);
        default: v = ror(32'(b), 2 * int'($urandom_range(0, 15)) + 1);
      endcase
      in_value  = v;
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 2) != 0);

      fire = in_valid && (!exp_valid || out_ready);
      pop  = exp_valid && out_ready;
      held = exp_valid && !out_ready;

      @(posedge clk);
      if (fire) begin
        exp_valid = 1'b1;
        exp_v = v;
        ref_enc(v, exp_ok, exp_n, exp_r);
      end else if (pop) begin
        exp_valid = 1'b0;
      end
      @(negedge clk);
    end

    in_valid = 1'b0;
    finish_run();
  end
endmodule